// File: doc/BRIEF.md
# Dual-Rail Minterm Complex Gate

This block is a configurable logic node with K logical inputs and one logical output. Every signal is carried on two rails, positive and negative, using a delay-insensitive code. A truth-table parameter of 2^K bits selects the function, so the node can stand in for any K-input function in the same way a lookup table does. Inside, each input combination has its own hysteresis element, and an OR stage merges these elements into the two output rails. The node therefore needs no separate logic to detect when its inputs are complete.

The node obeys a strict arrival rule. Its output stays at the spacer until every input carries a valid code. Once valid, the output holds its value until every input has gone back to the spacer. The hysteresis elements are modelled as registers that update on each clock edge, which keeps the design synthesizable. A flag reports any input that shows the illegal code, where both rails are high.

Top module: `dr_cgate`

## Requirements
- R1: While `rst_n` is low at a clock edge, every hysteresis element clears. After reset the output is the spacer {`out_pos`,`out_neg`} = 00, and `code_err` is 0.
- R2: A logical input j is valid when exactly one of `in_pos[j]`/`in_neg[j]` is high. Rails 10 mean logic 1, rails 01 mean logic 0, and rails 00 are the spacer. While at least one input is still at the spacer, an output that is at the spacer stays at the spacer.
- R3: At the first clock edge where all inputs are valid, the output becomes valid. It reads 10 if `TABLE[idx]` is 1 and 01 if it is 0. Here idx is the input word with input 0 as the least significant bit, and bit j is 1 when input j carries logic 1.
- R4: A valid output holds its value while at least one input has not yet returned to the spacer.
- R5: At the first clock edge where all inputs are at the spacer, the output returns to 00.
- R6: Every one of the 2^K input words gives the value that `TABLE` holds for that word.
- R7: `code_err` is high in the cycle after a clock edge at which any input shows rails 11, and low in the cycle after an edge at which no input does.
- R8: The output never shows rails 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that updates the hysteresis elements |
| rst_n | input | 1 | Synchronous reset, active low |
| in_pos | input | K | Positive rail of each logical input |
| in_neg | input | K | Negative rail of each logical input |
| out_pos | output | 1 | Positive (true) rail of the output |
| out_neg | output | 1 | Negative (false) rail of the output |
| code_err | output | 1 | Registered flag for an illegal 11 input code |

## Verification
The assertions assume the inputs follow the four-phase order. Each input goes from the spacer to a valid code and back to the spacer, and never jumps directly from one valid code to the other. An illegal 11 code appears only while the output and the other inputs are at the spacer. The stimulus meets these assumptions by changing one input per cycle, in a random order, until the word is complete. It then drops the inputs back to the spacer one by one before the next word starts. The illegal-code test is run only from an all-spacer state and ends there too.

// File: rtl/dr_cgate_pkg.sv
// Package dr_cgate_pkg
// Shared rail codes and small helper functions for the dual-rail gate.
// Codes are written {pos, neg}.
package dr_cgate_pkg;
    localparam logic [1:0] DR_SPACER = 2'b00;
    localparam logic [1:0] DR_ONE    = 2'b10;
    localparam logic [1:0] DR_ZERO   = 2'b01;
    localparam logic [1:0] DR_ILLEGAL = 2'b11;

    // True when exactly one rail is high.
    function automatic logic dr_valid(input logic p, input logic n);
        return p ^ n;
    endfunction

    // True when both rails are low.
    function automatic logic dr_spacer(input logic p, input logic n);
        return ~(p | n);
    endfunction
endpackage

// File: rtl/dr_minterm_celem.sv
// Module dr_minterm_celem
// The hysteresis element for one input word INDEX. For each input j it
// picks the positive rail when bit j of INDEX is 1 and the negative rail
// otherwise. The state sets when every picked rail is high, clears when
// every picked rail is low, and holds in all other cases.
// Assumes the rails arrive already sampled into the clock domain.
module dr_minterm_celem #(
    parameter int K     = 3,
    parameter int INDEX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] in_pos,
    input  logic [K-1:0] in_neg,
    output logic         state_o
);
    localparam logic [K-1:0] SEL = INDEX[K-1:0];

    logic [K-1:0] picked;
    logic         all_hi;
    logic         all_lo;

    // Pick the rail that each input contributes to this word.
    always_comb begin
        for (int j = 0; j < K; j++) begin
            picked[j] = SEL[j] ? in_pos[j] : in_neg[j];
        end
    end

    assign all_hi = &picked;
    assign all_lo = ~|picked;

    // Hysteresis register: set on all-high, clear on all-low, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_o <= 1'b0;
        else if (all_hi) state_o <= 1'b1;
        else if (all_lo) state_o <= 1'b0;
    end
endmodule

// File: rtl/dr_rail_merge.sv
// Module dr_rail_merge
// The OR stage. Word states whose table bit is 1 feed the true rail, and
// the others feed the false rail. As a guard, both rails are forced low if
// both would be high, which can only happen after illegal input codes.
module dr_rail_merge #(
    parameter int                   K     = 3,
    parameter logic [(1<<K)-1:0]    TABLE = '0
) (
    input  logic [(1<<K)-1:0] word_st,
    output logic              out_pos,
    output logic              out_neg
);
    logic raw_t;
    logic raw_f;

    // Sum of words for each polarity.
    always_comb begin
        raw_t = |(word_st & TABLE);
        raw_f = |(word_st & ~TABLE);
    end

    assign out_pos = raw_t & ~raw_f;
    assign out_neg = raw_f & ~raw_t;
endmodule

// File: rtl/dr_code_check.sv
// Module dr_code_check
// Registers a flag whenever any input shows the illegal 11 code.
// The flag is not sticky: it follows the inputs with a delay of one cycle.
module dr_code_check #(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] in_pos,
    input  logic [K-1:0] in_neg,
    output logic         err_o
);
    logic any_bad;

    assign any_bad = |(in_pos & in_neg);

    // Capture the illegal-code indication once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= any_bad;
    end
endmodule

// File: rtl/dr_cgate.sv
// Module dr_cgate
// A K-input dual-rail complex gate built as a sum of words. There is one
// hysteresis element per input word, and an OR stage drives both output
// rails. TABLE bit i holds the function value for input word i, with input
// 0 as the least significant bit.
// Assumes the inputs follow the four-phase order: spacer, then valid, then
// spacer, with no direct change between valid codes.
module dr_cgate #(
    parameter int                K     = 3,
    parameter logic [(1<<K)-1:0] TABLE = 8'hD2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] in_pos,
    input  logic [K-1:0] in_neg,
    output logic         out_pos,
    output logic         out_neg,
    output logic         code_err
);
    localparam int WORDS = 1 << K;

    logic [WORDS-1:0] word_st;

    // One hysteresis element for each input word.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        dr_minterm_celem #(.K(K), .INDEX(w)) celem_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_pos (in_pos),
            .in_neg (in_neg),
            .state_o(word_st[w])
        );
    end

    dr_rail_merge #(.K(K), .TABLE(TABLE)) merge_i (
        .word_st(word_st),
        .out_pos(out_pos),
        .out_neg(out_neg)
    );

    dr_code_check #(.K(K)) chk_code_i (
        .clk   (clk),
        .rst_n (rst_n),
        .in_pos(in_pos),
        .in_neg(in_neg),
        .err_o (code_err)
    );
endmodule

// File: rtl/dr_cgate_chk.sv
// Module dr_cgate_chk
// Temporal checks on the ports of dr_cgate. Assumes the inputs follow the
// four-phase order. Attached to every dr_cgate instance by the bind below.
module dr_cgate_chk #(
    parameter int                K     = 3,
    parameter logic [(1<<K)-1:0] TABLE = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [K-1:0] in_pos,
    input logic [K-1:0] in_neg,
    input logic         out_pos,
    input logic         out_neg,
    input logic         code_err
);
    logic all_valid;
    logic all_space;
    logic out_sp;
    logic any_bad;

    assign all_valid = &(in_pos ^ in_neg);
    assign all_space = ~|(in_pos | in_neg);
    assign out_sp    = ~(out_pos | out_neg);
    assign any_bad   = |(in_pos & in_neg);

    // R2: the output leaves the spacer only if the inputs were all valid at that edge.
    p_leave_spacer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_sp) && !out_sp) |-> $past(all_valid));

    // R3: the first valid output matches the table entry for the input word.
    p_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_sp) && !out_sp) |-> (out_pos == TABLE[$past(in_pos)]));

    // R4: a valid output is unchanged unless the inputs were all at the spacer.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(out_sp) && !$past(all_space)) |-> $stable({out_pos, out_neg}));

    // R5: all inputs at the spacer bring the output back to the spacer.
    p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        all_space |=> out_sp);

    // R7: the error flag follows the illegal code one cycle later.
    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> code_err);
    p_err_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !any_bad |=> !code_err);
endmodule

bind dr_cgate dr_cgate_chk #(.K(K), .TABLE(TABLE)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_pos  (in_pos),
    .in_neg  (in_neg),
    .out_pos (out_pos),
    .out_neg (out_neg),
    .code_err(code_err)
);

// File: tb/dr_cgate_tb_top.sv
// Scoreboard bench for dr_cgate. The driver queues the expected output
// code for each word, and the monitor checks each result as it appears.
module dr_cgate_tb_top;
    localparam int       K     = 3;
    localparam int       WORDS = 1 << K;
    localparam logic [WORDS-1:0] TBL = 8'hD2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [K-1:0] in_pos = '0;
    logic [K-1:0] in_neg = '0;
    logic         out_pos;
    logic         out_neg;
    logic         code_err;

    int n_run = 0;
    int n_fail = 0;
    int n_illegal_out = 0;
    logic [1:0] exp_q[$];

    always #2 clk = ~clk;

    dr_cgate #(.K(K), .TABLE(TBL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_pos(in_pos), .in_neg(in_neg),
        .out_pos(out_pos), .out_neg(out_neg), .code_err(code_err)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pop one expected code at each spacer-to-valid change and watch for 11.
    initial begin
        logic [1:0] prev = 2'b00;
        forever begin
            @(negedge clk);
            if ({out_pos, out_neg} == 2'b11) n_illegal_out++;
            if (rst_n && prev == 2'b00 && {out_pos, out_neg} != 2'b00) begin
                if (exp_q.size() == 0) check("R2 unexpected output", {out_pos, out_neg}, 2'b00);
                else check("R3/R6 value", {out_pos, out_neg}, exp_q.pop_front());
            end
            prev = {out_pos, out_neg};
        end
    end

    // Driver: one four-phase cycle for a word, with inputs arriving in random order.
    task automatic run_word(input logic [K-1:0] word);
        int ord[K];
        for (int i = 0; i < K; i++) ord[i] = i;
        for (int i = K - 1; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int t = ord[i];
            ord[i] = ord[j];
            ord[j] = t;
        end
        for (int i = 0; i < K; i++) begin
            if (i == K - 1) exp_q.push_back(TBL[word] ? 2'b10 : 2'b01);
            in_pos[ord[i]] = word[ord[i]];
            in_neg[ord[i]] = ~word[ord[i]];
            @(negedge clk);
            if (i < K - 1) check("R2 spacer while incomplete", {out_pos, out_neg}, 2'b00);
        end
        for (int i = K - 1; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int t = ord[i];
            ord[i] = ord[j];
            ord[j] = t;
        end
        for (int i = 0; i < K; i++) begin
            in_pos[ord[i]] = 1'b0;
            in_neg[ord[i]] = 1'b0;
            @(negedge clk);
            if (i < K - 1)
                check("R4 hold during return", {out_pos, out_neg}, TBL[word] ? 2'b10 : 2'b01);
            else
                check("R5 back to spacer", {out_pos, out_neg}, 2'b00);
        end
        if (exp_q.size() != 0) begin
            check("R3 output never appeared", 2'(exp_q.size()), 2'b00);
            exp_q.delete();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset output", {out_pos, out_neg}, 2'b00);
        check("R1 reset error flag", {1'b0, code_err}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 spacer after reset", {out_pos, out_neg}, 2'b00);
        // R6: sweep every input word.
        for (int w = 0; w < WORDS; w++) run_word(K'(w));
        // R3: random words.
        for (int n = 0; n < 24; n++) run_word(K'($urandom_range(WORDS - 1, 0)));
        // R7: illegal code on input 1, all other inputs at the spacer.
        in_pos[1] = 1'b1;
        in_neg[1] = 1'b1;
        @(negedge clk);
        check("R7 error flag set", {1'b0, code_err}, 2'b01);
        check("R8 output spacer under illegal code", {out_pos, out_neg}, 2'b00);
        in_pos[1] = 1'b0;
        in_neg[1] = 1'b0;
        @(negedge clk);
        check("R7 error flag cleared", {1'b0, code_err}, 2'b00);
        run_word(3'b101);
        check("R8 no 11 output seen", 2'(n_illegal_out != 0), 2'b00);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule